// File: doc/BRIEF.md
# Event-Model Delay Line

This block delays a single-bit signal by a fixed number of clock cycles. It can follow either of the two delay models that event-driven simulators use. In the filtering model, the output rejects any input pulse narrower than the delay. In the lossless model, every input edge is reproduced at the output, however close it lies to its neighbours. Time is counted in rising clock edges: the input is sampled once per edge, and the delay `DELAY` (at least 1) is fixed at build time.

In the filtering model, an input change seen at edge n books one future change of the output, due at edge n + `DELAY`. A later input change cancels a booking that is still waiting. If the new value equals what the output will hold, nothing is booked. If a booking falls due on the same edge as a new input change, the booking is applied first and the new change is then judged against the updated output. In the lossless model the input passes through a chain of sample stages, so any number of edges can be in flight at once.

The model is picked by a select pin that is captured only while reset is held. After reset it stays fixed until the next reset. The data path is one plain level in and one plain level out. There is no handshake, because a bit is taken and given on every edge.

Top module: `sim_delay_line`

## Requirements
- R1: While `rst` is high at a rising edge, the block clears all booked and in-flight changes, and `dout` reads 0 after that edge. `dout` then stays 0 until a 1 sampled on `din` after reset has had time to arrive.
- R2: `mode_sel` is captured at every rising edge with `rst` high: 0 selects the filtering model (the default), 1 selects the lossless model. Changes of `mode_sel` while `rst` is low have no effect on `dout`.
- R3: In the lossless model, `dout` after rising edge n + `DELAY` equals `din` as sampled at rising edge n.
- R4: In the lossless model, pulses of any width down to one cycle reach the output unaltered, including several pulses in flight at once.
- R5: In the filtering model, an input change first sampled at edge n, with no later input change before edge n + `DELAY`, makes `dout` take the new value at edge n + `DELAY` and at no earlier edge.
- R6: In the filtering model, an input pulse lasting fewer than `DELAY` cycles never appears at `dout`. The second edge of the pulse cancels the pending change.
- R7: In the filtering model, a pulse lasting exactly `DELAY` cycles or more appears at `dout` with its width preserved. A booking that falls due on the same edge as a new input change is applied before the new change is judged.
- R8: With `DELAY` = 30 in the filtering model, consider an input that is 0, turns 1 at edge 40, 0 at edge 45, 1 at edge 80 and 0 at edge 130. For this input, `dout` is 1 exactly on edges 110 to 159 and 0 elsewhere.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; one edge is one time unit |
| rst | input | 1 | Synchronous active-high reset; also captures `mode_sel` |
| mode_sel | input | 1 | Delay model: 0 filtering, 1 lossless; sampled only during reset |
| din | input | 1 | Signal to be delayed, sampled each rising edge |
| dout | output | 1 | Delayed signal |

## Verification
The filtering model is first driven with the fixed reference trace, whose 5-cycle glitch must vanish. Isolated pulses of width `DELAY`-1, `DELAY` and `DELAY`+1 follow; they separate strict rejection from pass-through at the boundary and catch off-by-one errors in the countdown. Random runs, with widths spread around `DELAY`, then tell a single cancellable booking apart from a plain shift register. In the lossless model, one-cycle pulses and dense random toggling show that no edge is dropped while many are in flight. The select pin is toggled mid-run and a reset lands with changes still pending, which shows that only reset re-arms the model choice and flushes state.

// File: rtl/sdl_pkg.sv
package sdl_pkg;

  typedef enum logic {
    MODE_FILTER   = 1'b0,
    MODE_LOSSLESS = 1'b1
  } sdl_mode_e;

  function automatic int unsigned cnt_width(input int unsigned dly);
    return (dly < 2) ? 1 : $clog2(dly + 1);
  endfunction

endpackage

// File: rtl/sdl_mode_latch.sv
module sdl_mode_latch
  import sdl_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      mode_sel,
  output sdl_mode_e mode
);

  sdl_mode_e mode_q;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= sdl_mode_e'(mode_sel);
  end

  assign mode = mode_q;

  // R2
  mode_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(mode_q));

endmodule

// File: rtl/sdl_lossless_chain.sv
module sdl_lossless_chain #(
  parameter int unsigned DELAY = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  localparam int unsigned STAGES = DELAY + 1;

  logic [STAGES-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= 1'b0;
    else     stage_q[0] <= din;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[k] <= 1'b0;
      else     stage_q[k] <= stage_q[k-1];
    end
  end

  assign dout = stage_q[STAGES-1];

  // R1
  chain_flushed_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (stage_q == '0));

endmodule

// File: rtl/sdl_filter_slot.sv
module sdl_filter_slot #(
  parameter int unsigned DELAY = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  localparam int unsigned CW = sdl_pkg::cnt_width(DELAY);
  localparam logic [CW-1:0] LOAD = CW'(DELAY);
  localparam logic [CW-1:0] LAST = CW'(1);

  logic          prev_q;
  logic          out_q;
  logic          pend_q;
  logic          tgt_q;
  logic [CW-1:0] cnt_q;

  logic          change;
  logic          due;
  logic          out_nx;

  assign change = (din != prev_q);
  assign due    = pend_q && (cnt_q == LAST);
  assign out_nx = due ? tgt_q : out_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      out_q  <= 1'b0;
      pend_q <= 1'b0;
      tgt_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= din;
      out_q  <= out_nx;
      if (change) begin
        if (din != out_nx) begin
          pend_q <= 1'b1;
          tgt_q  <= din;
          cnt_q  <= LOAD;
        end else begin
          pend_q <= 1'b0;
          cnt_q  <= '0;
        end
      end else if (pend_q) begin
        pend_q <= !due;
        cnt_q  <= cnt_q - LAST;
      end
    end
  end

  assign dout = out_q;

  // R1
  slot_cleared_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!pend_q && !out_q));

  // R5
  book_on_change_chk: assert property (@(posedge clk) disable iff (rst)
    (change && (din != out_nx)) |=> (pend_q && (cnt_q == LOAD) && (tgt_q == $past(din))));

  // R5
  hold_while_waiting_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_q && (cnt_q != LAST) && !change) |=> $stable(out_q));

  // R6
  booking_differs_chk: assert property (@(posedge clk) disable iff (rst)
    pend_q |-> (tgt_q != out_q));

endmodule

// File: rtl/sim_delay_line.sv
module sim_delay_line
  import sdl_pkg::*;
#(
  parameter int unsigned DELAY = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_sel,
  input  logic din,
  output logic dout
);

  sdl_mode_e mode;
  logic      filt_out;
  logic      loss_out;

  sdl_mode_latch u_mode (
    .clk      (clk),
    .rst      (rst),
    .mode_sel (mode_sel),
    .mode     (mode)
  );

  sdl_filter_slot #(.DELAY(DELAY)) u_filter (
    .clk  (clk),
    .rst  (rst),
    .din  (din),
    .dout (filt_out)
  );

  sdl_lossless_chain #(.DELAY(DELAY)) u_chain (
    .clk  (clk),
    .rst  (rst),
    .din  (din),
    .dout (loss_out)
  );

  assign dout = (mode == MODE_LOSSLESS) ? loss_out : filt_out;

  // R1
  out_low_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !dout);

endmodule

// File: tb/sim_delay_line_bench.sv
`timescale 1ns/1ps
module sim_delay_line_bench;

  localparam int DLY = 30;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_sel = 1'b0;
  logic din = 1'b0;
  logic dout;

  always #4 clk = ~clk;

  sim_delay_line #(.DELAY(DLY)) u_sim_delay_line (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .din(din), .dout(dout)
  );

  int checks = 0;
  int fails = 0;
  string tag = "R1";
  bit trace_on = 1'b0;
  bit seen_edge = 1'b0;
  bit done = 1'b0;

  // behavioural reference state
  bit ref_mode;
  int edge_n;
  bit hist[$];
  int due_q[$];
  bit val_q[$];
  bit prev_in;
  bit filt_ref;
  bit exp_out;
  bit in_reset;

  task automatic check(input bit ok, input string t, input bit act, input bit exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: dout=%0b expected=%0b edge=%0d", t, act, exp_v, edge_n - 1);
    end
  endtask

  always @(posedge clk) begin
    seen_edge = 1'b1;
    if (rst) begin
      in_reset = 1'b1;
      ref_mode = mode_sel;
      edge_n = 0;
      hist.delete();
      due_q.delete();
      val_q.delete();
      prev_in = 1'b0;
      filt_ref = 1'b0;
      exp_out = 1'b0;
    end else begin
      in_reset = 1'b0;
      hist.push_back(din);
      // apply bookings due now
      for (int i = due_q.size() - 1; i >= 0; i--) begin
        if (due_q[i] == edge_n) begin
          filt_ref = val_q[i];
          due_q.delete(i);
          val_q.delete(i);
        end
      end
      // new input change: drop waiting bookings of another value, book new one
      if (din != prev_in) begin
        for (int i = due_q.size() - 1; i >= 0; i--) begin
          if (val_q[i] != din) begin
            due_q.delete(i);
            val_q.delete(i);
          end
        end
        due_q.push_back(edge_n + DLY);
        val_q.push_back(din);
        prev_in = din;
      end
      if (ref_mode) exp_out = (edge_n >= DLY) ? hist[edge_n - DLY] : 1'b0;
      else          exp_out = filt_ref;
      edge_n++;
    end
  end

  always @(negedge clk) begin
    if (seen_edge && !done) begin
      if (in_reset) begin
        check(dout == 1'b0, "R1", dout, 1'b0);
      end else begin
        check(dout == exp_out, tag, dout, exp_out);
        if (trace_on) begin
          int k;
          bit lit;
          k = edge_n - 1;
          lit = (k >= 110 && k < 160);
          if (k == 69 || k == 75 || k == 109 || k == 110 || k == 159 || k == 160)
            check(dout == lit, "R8", dout, lit);
        end
      end
    end
  end

  task automatic hold(input bit v, input int n);
    din = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input bit m);
    @(negedge clk);
    rst = 1'b1;
    mode_sel = m;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  int lfsr = 32'h1ACE5;
  function automatic int next_rand();
    lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hB400_0000 : 0);
    return lfsr;
  endfunction

  initial begin
    // reset, default filtering model
    do_reset(1'b0);
    // R8 reference trace; glitch at 40..44 must vanish (R6)
    tag = "R6"; trace_on = 1'b1;
    hold(0, 40); hold(1, 5); hold(0, 35); hold(1, 50); hold(0, 70);
    trace_on = 1'b0;
    // boundary widths: R6 swallow, R7 pass
    tag = "R6"; hold(1, DLY - 1); hold(0, 2 * DLY);
    hold(1, 1); hold(0, 2 * DLY);
    tag = "R7"; hold(1, DLY); hold(0, 2 * DLY);
    hold(1, DLY + 1); hold(0, DLY); hold(1, DLY); hold(0, 2 * DLY);
    // R5 random runs, mode_sel toggled mid-run (R2)
    tag = "R5";
    for (int i = 0; i < 60; i++) begin
      if (i == 30) mode_sel = 1'b1;
      hold(din ^ 1'b1, 1 + (next_rand() % (2 * DLY)));
    end
    tag = "R2"; hold(din, 10); mode_sel = 1'b0; hold(din ^ 1'b1, 3 * DLY);
    // reset with changes pending, switch to lossless model
    tag = "R5"; hold(1'b0, 2); hold(1'b1, 5);
    do_reset(1'b1);
    tag = "R1"; hold(0, DLY + 5);
    // R4 single-cycle pulses, many in flight
    tag = "R4";
    for (int i = 0; i < 20; i++) begin hold(1, 1); hold(0, 1 + i % 3); end
    hold(0, 2 * DLY);
    // R3 random dense toggling, mode_sel toggled (R2)
    tag = "R3";
    for (int i = 0; i < 80; i++) begin
      if (i == 40) mode_sel = 1'b0;
      hold((next_rand() & 1) != 0, 1 + (next_rand() % 7));
    end
    tag = "R2"; hold(0, 2 * DLY);
    // back to filtering through reset
    do_reset(1'b0);
    tag = "R6"; hold(1, 3); hold(0, DLY + 5);
    tag = "R5"; hold(1, DLY + 2); hold(0, 2 * DLY + 2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule